// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two 32-bit integers and folds the 64-bit product into a 64-bit accumulator. The accumulator is held as two 32-bit words, HI for the upper half and LO for the lower half. Each operation is chosen by a 5-bit code that has four separate fields:

- signedness of the operands;
- whether the product is negated;
- how the product combines with the accumulator: replace, add or subtract;
- which half of the new accumulator is returned as a general-register result.

A separate return-enable pin selects the forms that only update HI:LO and return nothing.

An operation is issued through a valid/ready handshake, and only one operation is in flight at a time. The operand pair and the code are captured at the issue edge. The 64-bit product is registered on the next edge. On the edge after that, the accumulator is updated, the optional register result is written and `done` pulses for one cycle. The accumulator words and the result stay on their outputs until the next operation completes.

Top module: `hilo_mac`

## Requirements
- R1: While `rst_n` is low, `acc_hi`, `acc_lo` and `result` are zero, `done` is low and `issue_ready` is high.
- R2: An operation is accepted on a rising edge where `issue_valid` and `issue_ready` are both high. `issue_ready` is then low for the next two cycles and is high again in the cycle where `done` is high. While `issue_ready` is low, `issue_valid` and the operand and code inputs have no effect.
- R3: `done` is high for exactly one cycle, in the cycle that follows the second rising edge after the accepting edge.
- R4: Code bit 4 set selects signed operands, which are sign-extended to 64 bits. Code bit 4 clear selects unsigned operands, which are zero-extended.
- R5: Code bits 2:1 equal to 00 (or the spare value 11) write the 64-bit term to HI:LO, and the old accumulator value has no effect.
- R6: Code bits 2:1 equal to 01 add the term to the old HI:LO value. Code bits 2:1 equal to 10 subtract the term from it. Both wrap modulo 2^64.
- R7: Code bit 3 set makes the term zero minus the 64-bit product. When it is clear, the term is the product itself.
- R8: After every operation, `acc_lo` holds bits 31:0 and `acc_hi` holds bits 63:32 of the new 64-bit value.
- R9: With `ret_en` high at issue, `result` becomes the new HI word when code bit 0 is set and the new LO word when code bit 0 is clear.
- R10: With `ret_en` low at issue, `result` keeps its previous value while HI:LO is still updated.
- R11: `acc_hi`, `acc_lo` and `result` change only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Request to start an operation |
| issue_ready | output | 1 | Unit idle and able to accept an operation |
| op_code | input | 5 | {signed, negate, mode[1:0], return-HI} |
| ret_en | input | 1 | Write a register result for this operation |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Returned accumulator half |
| acc_hi | output | 32 | Accumulator upper word |
| acc_lo | output | 32 | Accumulator lower word |

## Verification
The handshake shape is checked on every cycle: the two busy cycles after an accept, the fixed completion latency, the single-cycle done pulse and the freezing of HI, LO and the result between completions. The arithmetic itself can only be shown by the bench's scenarios, which compare against a software model. That covers:

- sign versus zero extension;
- negation;
- the three accumulate modes and the spare mode;
- wraparound past 2^64;
- choice of the returned half;
- an operation that returns nothing.

The bench also changes the inputs while the unit is busy, to show that only the captured operands count.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  localparam int OP_W = 5;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_ADD  = 2'b01,
    ACC_SUB  = 2'b10,
    ACC_RSVD = 2'b11
  } acc_mode_e;

  // Field order is the op_code bit order: [4] signed, [3] negate, [2:1] mode, [0] HI.
  typedef struct packed {
    logic      is_signed;
    logic      negate;
    acc_mode_e mode;
    logic      hi_half;
  } mac_op_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_MULT  = 2'b01,
    ST_ACCUM = 2'b10
  } mac_state_e;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import hilo_mac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue_valid,
  output logic ready,
  output logic load_ops,
  output logic load_prod,
  output logic commit
);

  mac_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (issue_valid) state_d = ST_MULT;
      ST_MULT:  state_d = ST_ACCUM;
      ST_ACCUM: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ready     = (state_q == ST_IDLE);
  assign load_ops  = ready && issue_valid;
  assign load_prod = (state_q == ST_MULT);
  assign commit    = (state_q == ST_ACCUM);

endmodule

// File: rtl/mac_product.sv
module mac_product #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                is_signed,
  output logic [2*DATA_W-1:0] prod
);

  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] ext_a, ext_b;

  // Extension to full width; the truncated product is exact modulo 2^PROD_W.
  always_comb begin
    ext_a = {{DATA_W{is_signed & a[DATA_W-1]}}, a};
    ext_b = {{DATA_W{is_signed & b[DATA_W-1]}}, b};
    prod  = ext_a * ext_b;
  end

endmodule

// File: rtl/mac_combine.sv
module mac_combine
  import hilo_mac_pkg::*;
#(
  parameter int ACC_W = 64
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] prod,
  input  logic             negate,
  input  acc_mode_e        mode,
  output logic [ACC_W-1:0] sum
);

  logic [ACC_W-1:0] term;

  always_comb begin
    term = negate ? (~prod + {{(ACC_W-1){1'b0}}, 1'b1}) : prod;
    case (mode)
      ACC_ADD: sum = acc + term;
      ACC_SUB: sum = acc - term;
      default: sum = term;
    endcase
  end

endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [OP_W-1:0]   op_code,
  input  logic              ret_en,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo
);

  localparam int ACC_W = 2 * DATA_W;

  logic load_ops, load_prod, commit;

  mac_op_t           op_q, op_d;
  logic              ret_q, ret_d;
  logic [DATA_W-1:0] a_q, a_d, b_q, b_d;
  logic [ACC_W-1:0]  prod_q, prod_d, prod_c;
  logic [ACC_W-1:0]  acc_q, acc_d, sum_c;
  logic [DATA_W-1:0] res_q, res_d;
  logic              done_q, done_d;

  mac_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .ready      (issue_ready),
    .load_ops   (load_ops),
    .load_prod  (load_prod),
    .commit     (commit)
  );

  mac_product #(.DATA_W(DATA_W)) u_prod (
    .a        (a_q),
    .b        (b_q),
    .is_signed(op_q.is_signed),
    .prod     (prod_c)
  );

  mac_combine #(.ACC_W(ACC_W)) u_comb (
    .acc   (acc_q),
    .prod  (prod_q),
    .negate(op_q.negate),
    .mode  (op_q.mode),
    .sum   (sum_c)
  );

  // Next-state logic with explicit enables
  always_comb begin
    op_d   = load_ops  ? mac_op_t'(op_code) : op_q;
    ret_d  = load_ops  ? ret_en             : ret_q;
    a_d    = load_ops  ? src_a              : a_q;
    b_d    = load_ops  ? src_b              : b_q;
    prod_d = load_prod ? prod_c             : prod_q;
    acc_d  = commit    ? sum_c              : acc_q;
    res_d  = res_q;
    if (commit && ret_q)
      res_d = op_q.hi_half ? sum_c[ACC_W-1:DATA_W] : sum_c[DATA_W-1:0];
    done_d = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      ret_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      prod_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      op_q   <= op_d;
      ret_q  <= ret_d;
      a_q    <= a_d;
      b_q    <= b_d;
      prod_q <= prod_d;
      acc_q  <= acc_d;
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign done   = done_q;
  assign result = res_q;
  assign acc_hi = acc_q[ACC_W-1:DATA_W];
  assign acc_lo = acc_q[DATA_W-1:0];

endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] acc_hi,
  input logic [DATA_W-1:0] acc_lo
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (acc_hi == '0 && acc_lo == '0 && result == '0 && !done && issue_ready)
        else $error("p_reset_state_r1");
    end
  end

  p_busy_after_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> !issue_ready ##1 !issue_ready);

  p_ready_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> issue_ready);

  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> !done ##1 !done ##1 done);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(acc_hi) && $stable(acc_lo) && $stable(result)));

endmodule

bind hilo_mac hilo_mac_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_valid(issue_valid),
  .issue_ready(issue_ready),
  .done       (done),
  .result     (result),
  .acc_hi     (acc_hi),
  .acc_lo     (acc_lo)
);

// File: tb/hilo_mac_tb_top.sv
module hilo_mac_tb_top;

  logic        clk;
  logic        rst_n;
  logic        issue_valid;
  logic        issue_ready;
  logic [4:0]  op_code;
  logic        ret_en;
  logic [31:0] src_a, src_b;
  logic        done;
  logic [31:0] result, acc_hi, acc_lo;

  int checks;
  int fails;
  int cycles;
  bit finished;

  logic [63:0] m_acc;
  logic [31:0] m_res;

  hilo_mac dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .issue_ready(issue_ready),
    .op_code    (op_code),
    .ret_en     (ret_en),
    .src_a      (src_a),
    .src_b      (src_b),
    .done       (done),
    .result     (result),
    .acc_hi     (acc_hi),
    .acc_lo     (acc_lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_calc(input logic [63:0] acc, input logic [4:0] op,
                                           input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb, p, t;
    ea = op[4] ? {{32{a[31]}}, a} : {32'h0, a};          // R4
    eb = op[4] ? {{32{b[31]}}, b} : {32'h0, b};
    p  = ea * eb;
    t  = op[3] ? (64'h0 - p) : p;                        // R7
    case (op[2:1])
      2'b01:   return acc + t;                           // R6
      2'b10:   return acc - t;
      default: return t;                                 // R5
    endcase
  endfunction

  task automatic do_op(input logic [4:0] op, input logic ret, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] nv;
    @(negedge clk);
    chk(issue_ready == 1'b1, "R2 ready before issue", 64'(issue_ready), 64'd1);
    issue_valid = 1'b1; op_code = op; ret_en = ret; src_a = a; src_b = b;
    nv = ref_calc(m_acc, op, a, b);
    m_acc = nv;
    if (ret) m_res = op[0] ? nv[63:32] : nv[31:0];
    @(posedge clk);
    @(negedge clk);
    chk(!issue_ready, "R2 busy cycle 1", 64'(issue_ready), 64'd0);
    chk(!done, "R3 no early done 1", 64'(done), 64'd0);
    // R2: inputs changed while busy must have no effect
    op_code = 5'($urandom); ret_en = 1'($urandom); src_a = $urandom; src_b = $urandom;
    @(posedge clk);
    @(negedge clk);
    chk(!issue_ready, "R2 busy cycle 2", 64'(issue_ready), 64'd0);
    chk(!done, "R3 no early done 2", 64'(done), 64'd0);
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    chk(done, "R3 done at latency", 64'(done), 64'd1);
    chk(issue_ready, "R2 ready with done", 64'(issue_ready), 64'd1);
    chk(acc_hi == m_acc[63:32], "R8 HI word R4 R5 R6 R7", 64'(acc_hi), 64'(m_acc[63:32]));
    chk(acc_lo == m_acc[31:0], "R8 LO word R4 R5 R6 R7", 64'(acc_lo), 64'(m_acc[31:0]));
    chk(result == m_res, ret ? "R9 returned half" : "R10 result kept", 64'(result), 64'(m_res));
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R3 single pulse", 64'(done), 64'd0);
    chk(acc_hi == m_acc[63:32] && acc_lo == m_acc[31:0] && result == m_res, "R11 hold",
        {acc_hi, acc_lo}, m_acc);
  endtask

  initial begin
    int seed_val;
    checks = 0; fails = 0; cycles = 0; finished = 1'b0;
    m_acc = 64'h0; m_res = 32'h0;
    seed_val = $urandom(32'd2914);
    rst_n = 1'b0; issue_valid = 1'b0; op_code = '0; ret_en = 1'b0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(acc_hi == 0 && acc_lo == 0, "R1 HI:LO cleared", {acc_hi, acc_lo}, 64'h0);
    chk(result == 0, "R1 result cleared", 64'(result), 64'h0);
    chk(!done && issue_ready, "R1 done low ready high", {62'h0, done, issue_ready}, 64'h1);
    rst_n = 1'b1;

    // Directed corners
    do_op(5'b1_0_00_1, 1'b1, 32'h8000_0000, 32'h8000_0000); // R4 signed, HI returned
    do_op(5'b0_0_00_0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R4 unsigned, old acc ignored R5
    do_op(5'b1_1_00_0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0003); // R7 negated signed
    do_op(5'b0_1_00_1, 1'b1, 32'h0001_0000, 32'h0001_0000); // R7 negated unsigned
    do_op(5'b0_0_00_0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_op(5'b0_0_01_1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R6 add wraps past 2^64
    do_op(5'b1_0_10_0, 1'b1, 32'h7FFF_FFFF, 32'h8000_0000); // R6 subtract signed
    do_op(5'b1_1_10_1, 1'b1, 32'h0000_1234, 32'hFFFF_0001); // R7 with subtract
    do_op(5'b0_0_11_0, 1'b1, 32'h0000_0007, 32'h0000_0009); // R5 spare mode replaces
    do_op(5'b0_0_01_1, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0); // R10 no return
    do_op(5'b1_0_10_1, 1'b0, 32'hDEAD_BEEF, 32'h0000_0002); // R10 no return

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if ((i % 7) == 0) ra = {32{ra[0]}};
      if ((i % 11) == 0) rb = 32'h8000_0000;
      do_op(5'($urandom), ($urandom % 4) != 0, ra, rb);
    end

    finished = 1'b1;
    summary();
  end

endmodule